// File: doc/BRIEF.md
# Configuration Completion Receiver

This block sits on the completion receive path of a root port. Once a configuration request has gone out, the request side pulses a start input. The block then samples the incoming 64-bit completion beats at a fixed poll spacing. Each beat has a two-bit flag word that marks the start and the end of a packet. The start-of-packet beat supplies a three-bit completion status from its high word. The end-of-packet beat supplies the read data from its low word. When the end beat arrives, or when no end beat has come after a bounded number of polls, the block pulses `done` for one cycle. With that pulse it gives a result code and the read data. For sub-dword accesses the data is shifted down to bit 0, and the bits above the access width are cleared.

The controller has four states. **IDLE** waits for `req_start`. **SAMPLE** looks at the current beat. **GAP** counts out the poll spacing. **DONE** presents the result. The transitions are: IDLE→SAMPLE on start; SAMPLE→DONE on an end beat or on the final poll; SAMPLE→GAP when the poll did not finish and the spacing is over one cycle (SAMPLE→SAMPLE when the spacing is one); GAP→SAMPLE when the spacing counter reaches zero; DONE→IDLE always.

Top module: `cfg_cpl_receiver`

## Requirements
- R1: While reset is asserted, and after it until a start, `done` and `rx_pop` are 0.
- R2: `req_start` is accepted only in IDLE. A start pulse while a request is in progress changes neither the poll timing nor the result.
- R3: `rx_flags` bit 0 marks start of packet and bit 1 marks end of packet. Before a start beat has been recorded, a sampled beat is consumed (`rx_pop`=1) only if either flag is set. After a start beat, every sampled beat is consumed. `rx_pop` is 0 outside sampling cycles.
- R4: On a consumed start beat, the recorded completion status becomes `rx_hi[14:12]`. The other bits of `rx_hi` have no effect.
- R5: A consumed end beat with recorded status 0 yields `result`=0 (success) and the aligned low word as `rdata`. A beat with both flags uses the status from that same beat.
- R6: A consumed end beat with non-zero recorded status yields `result`=1 (completion error) and `rdata`=0.
- R7: The recorded status is reset to non-zero at each start, so an end beat with no start beat before it yields `result`=1.
- R8: If no end beat is consumed within MAX_POLLS samples, `result`=2 (timeout) and `rdata`=0.
- R9: The first sample is the cycle after the start edge, and later samples are POLL_GAP cycles apart. `done` is high in the cycle after the deciding sample.
- R10: `req_size`=0 (byte): `rdata` = (low word >> 8·`req_lane`) & 0xFF.
- R11: `req_size`=1 (halfword): `rdata` = (low word >> 8·(`req_lane` & 2)) & 0xFFFF.
- R12: `req_size`=2 or 3 (word): `rdata` is the full low word.
- R13: `done` is high for exactly one cycle per request, and the block is idle in the next cycle.
- R14: An end beat consumed on the final permitted poll reports its completion outcome, not a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Pulse: a request was issued, begin watching |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| req_lane | input | 2 | Low two address bits of the access |
| rx_flags | input | 2 | Beat flags: bit 0 start, bit 1 end of packet |
| rx_lo | input | 32 | Low word of the current beat |
| rx_hi | input | 32 | High word of the current beat |
| rx_pop | output | 1 | Current beat consumed at this clock edge |
| done | output | 1 | One-cycle result strobe |
| result | output | 2 | 0 success, 1 completion error, 2 timeout |
| rdata | output | 32 | Aligned read data, 0 unless success |

## Verification
Two decisions can fall on the same sample. The first case is a single beat that carries both flags. Its status must be recorded and judged in the same cycle, and the bench sends such beats with zero and non-zero status. The second case is an end beat that reaches the final permitted poll. The bench times that beat to land exactly on the last sample and expects the completion outcome, not a timeout. A behavioural model predicts every `rx_pop` and `done` cycle and compares them with the design each clock.

// File: rtl/cplrx_pkg.sv
package cplrx_pkg;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CPL_ERR = 2'd1,
        RES_TIMEOUT = 2'd2
    } cpl_result_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_GAP,
        ST_DONE
    } rx_state_e;

    localparam int FLAG_SOP = 0;
    localparam int FLAG_EOP = 1;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam int WORD_W = 32;
    localparam int STAT_W = 3;

endpackage

// File: rtl/cplrx_poll_timer.sv
module cplrx_poll_timer #(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic poll_tick,
    input  logic in_gap,
    output logic last_poll,
    output logic gap_over
);

    localparam int PCNT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;

    logic [PCNT_W-1:0] poll_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            poll_cnt <= '0;
        end else if (poll_tick && !last_poll) begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    assign last_poll = (poll_cnt == PCNT_W'(MAX_POLLS - 1));

    a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PCNT_W'(MAX_POLLS - 1));

    generate
        if (POLL_GAP > 1) begin : g_gap
            localparam int GAP_W = (POLL_GAP > 2) ? $clog2(POLL_GAP - 1) : 1;
            logic [GAP_W-1:0] gap_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    gap_cnt <= '0;
                end else if (poll_tick) begin
                    gap_cnt <= GAP_W'(POLL_GAP - 2);
                end else if (in_gap && gap_cnt != '0) begin
                    gap_cnt <= gap_cnt - 1'b1;
                end
            end

            assign gap_over = (gap_cnt == '0);

            // R9: the spacing counter never counts past its load value
            a_r9_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
                gap_cnt <= GAP_W'(POLL_GAP - 2));
        end else begin : g_nogap
            logic unused_gap;
            assign unused_gap = in_gap;
            assign gap_over   = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/cplrx_lane_align.sv
module cplrx_lane_align
    import cplrx_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        size,
    input  logic [1:0]        lane,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] by_byte;
    logic [WORD_W-1:0] by_half;

    always_comb begin
        by_byte = word_in >> {lane, 3'b000};
        by_half = word_in >> {lane[1], 4'b0000};
        case (size)
            SZ_BYTE: word_out = {{(WORD_W-8){1'b0}},  by_byte[7:0]};
            SZ_HALF: word_out = {{(WORD_W-16){1'b0}}, by_half[15:0]};
            default: word_out = word_in;
        endcase
    end

endmodule

// File: rtl/cfg_cpl_receiver.sv
module cfg_cpl_receiver
    import cplrx_pkg::*;
#(
    parameter int POLL_GAP  = 4,
    parameter int MAX_POLLS = 500,
    parameter int STAT_LSB  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic [1:0]  req_size,
    input  logic [1:0]  req_lane,
    input  logic [1:0]  rx_flags,
    input  logic [31:0] rx_lo,
    input  logic [31:0] rx_hi,
    output logic        rx_pop,
    output logic        done,
    output logic [1:0]  result,
    output logic [31:0] rdata
);

    localparam logic [STAT_W-1:0] STAT_INIT = '1;
    localparam bit HAS_GAP = (POLL_GAP > 1);

    rx_state_e         state, state_nx;
    logic              sop_seen;
    logic [STAT_W-1:0] stat_q;
    logic [1:0]        size_q, lane_q;
    cpl_result_e       res_q;
    logic [WORD_W-1:0] data_q;

    logic              take, has_sop, has_eop;
    logic [STAT_W-1:0] eff_stat;
    logic              accept, poll_tick, last_poll, gap_over;
    logic [WORD_W-1:0] aligned;
    logic              unused_hi;

    assign unused_hi = ^rx_hi;

    // beat decode for the sampling cycle
    always_comb begin
        take      = (state == ST_SAMPLE) && ((rx_flags != 2'b00) || sop_seen);
        has_sop   = take && rx_flags[FLAG_SOP];
        has_eop   = take && rx_flags[FLAG_EOP];
        eff_stat  = has_sop ? rx_hi[STAT_LSB +: STAT_W] : stat_q;
        accept    = (state == ST_IDLE) && req_start;
        poll_tick = (state == ST_SAMPLE) && !has_eop;
    end

    cplrx_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .poll_tick (poll_tick),
        .in_gap    (state == ST_GAP),
        .last_poll (last_poll),
        .gap_over  (gap_over)
    );

    cplrx_lane_align u_align (
        .word_in  (rx_lo),
        .size     (size_q),
        .lane     (lane_q),
        .word_out (aligned)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_start) state_nx = ST_SAMPLE;
            ST_SAMPLE: begin
                if (has_eop || last_poll) state_nx = ST_DONE;
                else if (HAS_GAP)         state_nx = ST_GAP;
                else                      state_nx = ST_SAMPLE;
            end
            ST_GAP:    if (gap_over) state_nx = ST_SAMPLE;
            ST_DONE:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request context and completion capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sop_seen <= 1'b0;
            stat_q   <= STAT_INIT;
            size_q   <= '0;
            lane_q   <= '0;
            res_q    <= RES_OK;
            data_q   <= '0;
        end else if (accept) begin
            sop_seen <= 1'b0;
            stat_q   <= STAT_INIT;
            size_q   <= req_size;
            lane_q   <= req_lane;
        end else if (state == ST_SAMPLE) begin
            if (has_sop) begin
                sop_seen <= 1'b1;
                stat_q   <= eff_stat;
            end
            if (has_eop) begin
                res_q  <= (eff_stat != '0) ? RES_CPL_ERR : RES_OK;
                data_q <= (eff_stat != '0) ? '0 : aligned;
            end else if (last_poll) begin
                res_q  <= RES_TIMEOUT;
                data_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        rx_pop = take;
        done   = (state == ST_DONE);
        result = res_q;
        rdata  = data_q;
    end

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_no_pop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rx_pop);

    a_r6_fail_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_OK) |-> (rdata == '0));

    a_r7_ok_needs_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK) |-> sop_seen);

    a_r10_byte_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK && size_q == SZ_BYTE) |-> (rdata[31:8] == '0));

    a_r11_half_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK && size_q == SZ_HALF) |-> (rdata[31:16] == '0));

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req_start) |=> !rx_pop);

endmodule

// File: tb/cfg_cpl_receiver_test.sv
`timescale 1ns/100ps
module cfg_cpl_receiver_test;

    localparam int GAP  = 3;
    localparam int MAXP = 12;

    typedef struct {
        logic [1:0]  f;
        logic [31:0] lo;
        logic [31:0] hi;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [1:0]  req_lane = 2'd0;
    logic [1:0]  rx_flags = 2'd0;
    logic [31:0] rx_lo = 32'h0;
    logic [31:0] rx_hi = 32'h0;
    logic        rx_pop, done;
    logic [1:0]  result;
    logic [31:0] rdata;

    int    n_run = 0, n_fail = 0, cyc = 0;
    bit    fin = 1'b0, pop_seen = 1'b0;
    beat_t bq[$];

    always #2.5 clk = ~clk;

    cfg_cpl_receiver #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_size(req_size),
        .req_lane(req_lane), .rx_flags(rx_flags), .rx_lo(rx_lo), .rx_hi(rx_hi),
        .rx_pop(rx_pop), .done(done), .result(result), .rdata(rdata));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ext(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] ln);
        int sh;
        if (sz == 2'd0) begin sh = 8 * ln;       return (w >> sh) & 32'hFF;   end
        if (sz == 2'd1) begin sh = 8 * (ln & 2); return (w >> sh) & 32'hFFFF; end
        return w;
    endfunction

    // beat source: head of queue, garbage when empty
    task automatic refresh();
        if (bq.size() > 0) begin
            rx_flags = bq[0].f; rx_lo = bq[0].lo; rx_hi = bq[0].hi;
        end else begin
            rx_flags = 2'b00; rx_lo = 32'hDEAD_0000 + cyc; rx_hi = 32'hFFFF_FFFF;
        end
    endtask

    task automatic push(input logic [1:0] f, input logic [31:0] lo, input logic [31:0] hi);
        beat_t b;
        b.f = f; b.lo = lo; b.hi = hi;
        bq.push_back(b);
        refresh();
    endtask

    always @(posedge clk) cyc++;
    always @(negedge clk) pop_seen = rx_pop;
    always @(posedge clk) begin
        #0.5;
        if (pop_seen && bq.size() > 0) void'(bq.pop_front());
        refresh();
    end

    // behavioural reference model
    int          m_phase = 0, m_wait = 0, m_polls = 0;
    bit          m_seen = 0, m_c, m_e;
    logic [2:0]  m_stat = 3'b111;
    logic [1:0]  m_res = 2'd0, m_size = 2'd0, m_lane = 2'd0;
    logic [31:0] m_data = 32'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (req_start) begin
                    m_phase = 1; m_wait = 0; m_polls = 0; m_seen = 0;
                    m_stat = 3'b111; m_size = req_size; m_lane = req_lane;
                end
                1: if (m_wait > 0) m_wait--;
                   else begin
                    m_c = (rx_flags != 2'b00) || m_seen;
                    m_e = m_c && rx_flags[1];
                    if (m_c && rx_flags[0]) begin m_seen = 1; m_stat = rx_hi[14:12]; end
                    if (m_e) begin
                        m_phase = 2;
                        if (m_stat != 0) begin m_res = 2'd1; m_data = 0; end
                        else begin m_res = 2'd0; m_data = ext(rx_lo, m_size, m_lane); end
                    end else begin
                        m_polls++;
                        if (m_polls == MAXP) begin m_phase = 2; m_res = 2'd2; m_data = 0; end
                        else m_wait = GAP - 1;
                    end
                end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(done == (m_phase == 2), "R13 done vs model", {31'b0, done}, {31'b0, m_phase == 2});
            chk(rx_pop == ((m_phase == 1) && (m_wait == 0) && ((rx_flags != 0) || m_seen)),
                "R3 pop vs model", {31'b0, rx_pop}, 32'h0);
            if (done) begin
                chk(result == m_res, "R5 result vs model", {30'b0, result}, {30'b0, m_res});
                chk(rdata == m_data, "R5 rdata vs model", rdata, m_data);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !fin) begin
            fin = 1'b1;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    int t0;

    task automatic start_req(input logic [1:0] sz, input logic [1:0] ln);
        @(posedge clk); #1;
        req_start = 1'b1; req_size = sz; req_lane = ln;
        @(posedge clk); #1;
        t0 = cyc;
        req_start = 1'b0;
    endtask

    task automatic wait_done(input logic [1:0] er, input logic [31:0] ed, input string tag, output int when);
        int n;
        n = 0;
        @(negedge clk);
        while (!done && n < 2000) begin @(negedge clk); n++; end
        when = cyc;
        chk(done === 1'b1, {tag, " done seen"}, {31'b0, done}, 32'h1);
        chk(result === er, {tag, " result"}, {30'b0, result}, {30'b0, er});
        chk(rdata === ed, {tag, " rdata"}, rdata, ed);
        @(negedge clk);
        chk(done === 1'b0, "R13 done single cycle", {31'b0, done}, 32'h0);
        chk(rx_pop === 1'b0, "R13 idle after done", {31'b0, rx_pop}, 32'h0);
    endtask

    int w;

    initial begin
        refresh();
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R1 done in reset", {31'b0, done}, 32'h0);
        chk(rx_pop === 1'b0, "R1 pop in reset", {31'b0, rx_pop}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 R2: a waiting start beat is not taken while idle
        push(2'b11, 32'h1234_5678, 32'h0);
        repeat (4) @(negedge clk);
        chk(rx_pop === 1'b0, "R1 no pop while idle", {31'b0, rx_pop}, 32'h0);
        chk(bq.size() == 1, "R2 beat kept while idle", bq.size(), 32'd1);
        start_req(2'd2, 2'd0);
        wait_done(2'd0, 32'h1234_5678, "R5 R12 both-flag beat", w);

        // R3 R12: three-beat word read, middle beat without flags
        start_req(2'd2, 2'd0);
        push(2'b01, 32'h0, 32'h0000_0000);
        push(2'b00, 32'h5555_5555, 32'hFFFF_FFFF);
        push(2'b10, 32'hA1B2_C3D4, 32'h0);
        wait_done(2'd0, 32'hA1B2_C3D4, "R3 R12 multi-beat", w);

        // R10 byte lane 2
        start_req(2'd0, 2'd2);
        push(2'b11, 32'h1122_3344, 32'h0);
        wait_done(2'd0, 32'h0000_0022, "R10 byte lane2", w);

        // R11 halfword lanes 3 and 1
        start_req(2'd1, 2'd3);
        push(2'b11, 32'hCAFE_BEEF, 32'h0);
        wait_done(2'd0, 32'h0000_CAFE, "R11 half lane3", w);
        start_req(2'd1, 2'd1);
        push(2'b11, 32'hCAFE_BEEF, 32'h0);
        wait_done(2'd0, 32'h0000_BEEF, "R11 half lane1", w);

        // R4 R6: non-zero status in bits 14:12
        start_req(2'd2, 2'd0);
        push(2'b01, 32'h0, 32'h0000_2000);
        push(2'b10, 32'h7777_7777, 32'h0);
        wait_done(2'd1, 32'h0, "R4 R6 status error", w);

        // R4: status field zero, all other high bits set
        start_req(2'd2, 2'd0);
        push(2'b11, 32'h0BAD_F00D, 32'hFFFF_8FFF);
        wait_done(2'd0, 32'h0BAD_F00D, "R4 other bits ignored", w);

        // R7: end beat without start beat
        start_req(2'd2, 2'd0);
        push(2'b10, 32'h1111_1111, 32'h0);
        wait_done(2'd1, 32'h0, "R7 eop without sop", w);

        // R8 R9 R2: timeout, with a stray start while busy
        start_req(2'd2, 2'd0);
        repeat (5) @(posedge clk);
        #1 req_start = 1'b1;
        @(posedge clk); #1 req_start = 1'b0;
        wait_done(2'd2, 32'h0, "R8 timeout", w);
        chk(w == t0 + 1 + (MAXP - 1) * GAP, "R9 R2 timeout cycle", w, t0 + 1 + (MAXP - 1) * GAP);

        // R14: end beat lands on the final poll
        start_req(2'd0, 2'd1);
        repeat ((MAXP - 2) * GAP + 2) @(posedge clk);
        #1 push(2'b11, 32'h0000_9A00, 32'h0);
        wait_done(2'd0, 32'h0000_009A, "R14 eop on last poll", w);
        chk(w == t0 + 1 + (MAXP - 1) * GAP, "R14 decided on last poll", w, t0 + 1 + (MAXP - 1) * GAP);

        repeat (3) @(negedge clk);
        fin = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule